// File: doc/BRIEF.md
# TDM Audio Serial Transmitter (Clock Master)

This block is the transmit side of an audio serial port that owns the bus clocks. A programmable divider turns the reference clock into a bit clock. A frame counter marks each frame with a one-bit-wide word-clock pulse. One parallel PCM sample per frame goes out on the data pin, most significant bit first. The sample starts at a chosen number of bit clocks after the frame edge. Outside that window the pin can release the line, so several transmitters can share one time-division multiplexed bus, each in its own slot.

Samples come in over a ready/valid handshake that the block offers once per frame. If no sample is offered, the previous one is sent again. Configuration inputs are captured while the port is idle and at each frame boundary, so a frame never mixes two configurations. The clocks run only while the converter is powered, unless the keep-alive input is set. Removing interface power releases every output pin.

Top module: `tdm_tx_master`

## Requirements
- R1: The bit-clock period is N reference cycles, where N = cfg_div for codes 2..127, code 0 gives N = 128 and code 1 gives N = 2. With cfg_inv low, each bit period starts with bclk_o low for floor(N/2) cycles, and bclk_o is high for the rest.
- R2: A frame lasts cfg_len+1 bit clocks, and codes below 15 give 16 bit clocks. wclk_o is high during exactly the first bit clock of each frame.
- R3: cfg_wsel selects the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32, taken from s_data bits W-1..0. Slot bit k (k = 0 first) is sample bit W-1-k and is sent in bit clock cfg_offset+k of the frame. Slot bits that fall past the end of the frame are dropped.
- R4: sdout_o changes only at the start of a bit period. That moment is the falling edge of bclk_o when cfg_inv = 0. When cfg_inv = 1, bclk_o is complemented, so the data changes on the rising edge and stays stable across the falling edge.
- R5: With cfg_hiz = 1, sdout_oe is low in every bit clock outside the slot. With cfg_hiz = 0, the pin is driven all the time and carries 0 outside the slot.
- R6: s_ready is high for one reference cycle, the last cycle of each frame. A sample accepted there is sent in the next frame. If no sample is accepted, the previous sample is sent again. After reset the held sample is zero.
- R7: Configuration inputs are captured on every cycle while the port is idle, and otherwise only at the end of a frame. A change made mid-frame has no effect until the next frame.
- R8: While if_pwr is low, bclk_oe, wclk_oe and sdout_oe are all low, and bclk_o, wclk_o, sdout_o and s_ready are all low.
- R9: The clocks run while if_pwr is high and either conv_on or keep_alive is high. Otherwise bclk_o and wclk_o are held low and the counters are cleared, so that running resumes at the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_pwr | input | 1 | Serial interface powered |
| conv_on | input | 1 | Converter powered |
| keep_alive | input | 1 | Run clocks even with the converter off |
| cfg_div | input | 7 | Bit-clock divide code |
| cfg_len | input | 8 | Frame length code (bit clocks minus one) |
| cfg_offset | input | 8 | Slot start, in bit clocks after the frame edge |
| cfg_wsel | input | 2 | Word-length select |
| cfg_inv | input | 1 | Invert bit-clock polarity |
| cfg_hiz | input | 1 | Release data pin outside the slot |
| s_data | input | 32 | Parallel sample |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample taken this cycle |
| bclk_o | output | 1 | Bit clock |
| bclk_oe | output | 1 | Bit-clock pin enable |
| wclk_o | output | 1 | Word clock |
| wclk_oe | output | 1 | Word-clock pin enable |
| sdout_o | output | 1 | Serial data |
| sdout_oe | output | 1 | Serial-data pin enable |

## Verification
The assertions assume that the power inputs and the configuration inputs change only between reference-clock edges. They also assume that a divide code of 1 never reaches the divider as a ratio of one, since the code is mapped to two. The bench changes every input half a cycle away from the active edge. It sweeps word length, offset, polarity, release mode and small divide ratios over a 40-bit frame, plus one short frame at the largest ratio. Some offsets push the slot past the frame end. s_valid is withheld in every third frame to exercise the repeat path. Mid-frame configuration changes and power removal happen at arbitrary cycles, and the bench model applies them at the next frame boundary or at once, as R7 to R9 require.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int DIV_W  = 7;
  localparam int RAT_W  = DIV_W + 1;
  localparam int CNT_W  = 8;
  localparam int LEN_W  = CNT_W + 1;
  localparam int SAMP_W = 32;
  localparam int IDX_W  = $clog2(SAMP_W);
  localparam int WB_W   = IDX_W + 1;

  typedef struct packed {
    logic [DIV_W-1:0] div_code;
    logic [CNT_W-1:0] len_code;
    logic [CNT_W-1:0] offset;
    logic [1:0]       wsel;
    logic             inv;
    logic             hiz;
  } tdm_cfg_t;

  // divide code to ratio: 0 -> 2^DIV_W, 1 -> 2, others as given
  function automatic logic [RAT_W-1:0] div_ratio(input logic [DIV_W-1:0] code);
    if (code == '0)              return RAT_W'(1) << DIV_W;
    else if (code == DIV_W'(1))  return RAT_W'(2);
    else                         return {1'b0, code};
  endfunction

  // frame code to bit clocks per frame, minimum 16
  function automatic logic [LEN_W-1:0] frame_bits(input logic [CNT_W-1:0] code);
    if (code < CNT_W'(15)) return LEN_W'(16);
    else                   return {1'b0, code} + LEN_W'(1);
  endfunction

  function automatic logic [WB_W-1:0] word_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return WB_W'(16);
      2'd1:    return WB_W'(20);
      2'd2:    return WB_W'(24);
      default: return WB_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/tdm_bclk_div.sv
module tdm_bclk_div #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] ratio,
  output logic          tick,
  output logic          phase_hi,
  output logic          at_start
);
  logic [RW-1:0] cnt_q;
  logic          last;

  assign last     = (cnt_q == ratio - RW'(1));
  assign tick     = run && last;
  assign phase_hi = (cnt_q >= (ratio >> 1));
  assign at_start = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || last)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + RW'(1);
  end

  // R1
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < ratio));
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int CW = 8,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [LW-1:0] flen,
  output logic [CW-1:0] bit_cnt,
  output logic          frame_end,
  output logic          word_pulse
);
  logic [CW-1:0] bit_q;
  logic          last_bit;

  assign last_bit   = ({{(LW-CW){1'b0}}, bit_q} == flen - LW'(1));
  assign frame_end  = tick && last_bit;
  assign word_pulse = run && (bit_q == '0);
  assign bit_cnt    = bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  bit_q <= '0;
    else if (!run || frame_end)  bit_q <= '0;
    else if (tick)               bit_q <= bit_q + CW'(1);
  end

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bit_q == '0));
  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({{(LW-CW){1'b0}}, bit_q} < flen));
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
  parameter int CW  = 8,
  parameter int SW  = 32,
  parameter int IW  = 5,
  parameter int WBW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           take,
  input  logic [SW-1:0]  s_data,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [CW-1:0]  bit_cnt,
  input  logic [CW-1:0]  offset,
  input  logic [WBW-1:0] wbits,
  output logic           in_slot,
  output logic           data_bit
);
  logic [SW-1:0]  samp_q;
  logic [CW:0]    rel;
  logic [WBW-1:0] idx;

  assign s_ready  = take;
  assign rel      = {1'b0, bit_cnt} - {1'b0, offset};
  assign in_slot  = run && (bit_cnt >= offset) &&
                    (rel < {{(CW+1-WBW){1'b0}}, wbits});
  assign idx      = wbits - WBW'(1) - rel[WBW-1:0];
  assign data_bit = in_slot && samp_q[idx[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)                samp_q <= '0;
    else if (take && s_valid)  samp_q <= s_data;
  end

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);
  // R6
  samp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && s_valid) |=> $stable(samp_q));
endmodule

// File: rtl/tdm_tx_master.sv
module tdm_tx_master
  import tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_pwr,
  input  logic              conv_on,
  input  logic              keep_alive,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [CNT_W-1:0]  cfg_len,
  input  logic [CNT_W-1:0]  cfg_offset,
  input  logic [1:0]        cfg_wsel,
  input  logic              cfg_inv,
  input  logic              cfg_hiz,
  input  logic [SAMP_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              bclk_o,
  output logic              bclk_oe,
  output logic              wclk_o,
  output logic              wclk_oe,
  output logic              sdout_o,
  output logic              sdout_oe
);
  tdm_cfg_t         cfg_in, act_q;
  logic             run;
  logic             tick, phase_hi, at_start;
  logic             frame_end, word_pulse;
  logic [CNT_W-1:0] bit_cnt;
  logic             in_slot, data_bit;
  logic [RAT_W-1:0] ratio;
  logic [LEN_W-1:0] flen;
  logic [WB_W-1:0]  wbits;

  assign run   = if_pwr && (conv_on || keep_alive);
  assign ratio = div_ratio(act_q.div_code);
  assign flen  = frame_bits(act_q.len_code);
  assign wbits = word_bits(act_q.wsel);

  always_comb begin
    cfg_in          = '0;
    cfg_in.div_code = cfg_div;
    cfg_in.len_code = cfg_len;
    cfg_in.offset   = cfg_offset;
    cfg_in.wsel     = cfg_wsel;
    cfg_in.inv      = cfg_inv;
    cfg_in.hiz      = cfg_hiz;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 act_q <= '0;
    else if (!run || frame_end) act_q <= cfg_in;
  end

  tdm_bclk_div #(.RW(RAT_W)) div_i (
    .clk(clk), .rst_n(rst_n), .run(run), .ratio(ratio),
    .tick(tick), .phase_hi(phase_hi), .at_start(at_start)
  );

  tdm_frame_ctr #(.CW(CNT_W), .LW(LEN_W)) frm_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .flen(flen),
    .bit_cnt(bit_cnt), .frame_end(frame_end), .word_pulse(word_pulse)
  );

  tdm_slot_tx #(.CW(CNT_W), .SW(SAMP_W), .IW(IDX_W), .WBW(WB_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .run(run), .take(frame_end),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .bit_cnt(bit_cnt), .offset(act_q.offset), .wbits(wbits),
    .in_slot(in_slot), .data_bit(data_bit)
  );

  assign bclk_o   = run && (phase_hi ^ act_q.inv);
  assign wclk_o   = word_pulse;
  assign sdout_o  = data_bit;
  assign bclk_oe  = if_pwr;
  assign wclk_oe  = if_pwr;
  assign sdout_oe = if_pwr && (in_slot || !act_q.hiz);

  // R8
  pwr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_pwr |-> !(bclk_oe || wclk_oe || sdout_oe || s_ready));
  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(frame_end)) |-> $stable(act_q));
  // R4
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !at_start) |-> $stable(sdout_o));
  // R9
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(bclk_o || wclk_o));
endmodule

// File: tb/tdm_tx_master_tb_top.sv
module tdm_tx_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_pwr = 1'b0, conv_on = 1'b0, keep_alive = 1'b0;
  logic [6:0] cfg_div = '0;
  logic [7:0] cfg_len = '0, cfg_offset = '0;
  logic [1:0] cfg_wsel = '0;
  logic cfg_inv = 1'b0, cfg_hiz = 1'b0;
  logic [31:0] s_data = '0;
  logic s_valid = 1'b0;
  logic s_ready, bclk_o, bclk_oe, wclk_o, wclk_oe, sdout_o, sdout_oe;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // bench model state
  int m_phase = 0, m_bit = 0, m_ratio = 128, m_flen = 16, m_off = 0, m_w = 16;
  bit m_inv = 0, m_hiz = 0;
  int frame_idx = 0, acc = 0;
  logic [31:0] cur_samp = '0, nxt_samp = '0;
  logic [31:0] prev_data = '0;
  bit prev_valid = 0, prev_ready = 0;

  always #2 clk = ~clk;

  tdm_tx_master dut_i (
    .clk(clk), .rst_n(rst_n), .if_pwr(if_pwr), .conv_on(conv_on),
    .keep_alive(keep_alive), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_offset(cfg_offset), .cfg_wsel(cfg_wsel), .cfg_inv(cfg_inv),
    .cfg_hiz(cfg_hiz), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .wclk_o(wclk_o), .wclk_oe(wclk_oe),
    .sdout_o(sdout_o), .sdout_oe(sdout_oe)
  );

  function automatic int ratio_of(input int code);
    if (code == 0) return 128;
    if (code == 1) return 2;
    return code;
  endfunction
  function automatic int flen_of(input int code);
    return (code < 15) ? 16 : code + 1;
  endfunction
  function automatic int wb_of(input int sel);
    return (sel == 3) ? 32 : 16 + 4 * sel;
  endfunction
  function automatic logic [31:0] gen(input int k);
    return 32'hA5C3_0F1E ^ (32'(k) * 32'h9E37_79B1);
  endfunction

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cyc, got, exp);
    end
  endtask

  task automatic latch_cfg();
    m_ratio = ratio_of(int'(cfg_div));
    m_flen  = flen_of(int'(cfg_len));
    m_off   = int'(cfg_offset);
    m_w     = wb_of(int'(cfg_wsel));
    m_inv   = cfg_inv;
    m_hiz   = cfg_hiz;
  endtask

  // one reference cycle: advance model over the posedge just passed, then check
  task automatic step();
    bit run, in_slot, e_rdy;
    logic e_bclk, e_sd;
    @(negedge clk);
    run = if_pwr && (conv_on || keep_alive);
    if (run) begin
      if (prev_ready && prev_valid) begin nxt_samp = prev_data; acc++; end
      if (m_phase == m_ratio - 1) begin
        m_phase = 0;
        if (m_bit == m_flen - 1) begin
          m_bit = 0; frame_idx++; cur_samp = nxt_samp; latch_cfg();
        end else m_bit++;
      end else m_phase++;
    end else begin
      m_phase = 0; m_bit = 0; latch_cfg();
    end
    s_data  = gen(acc);
    s_valid = (frame_idx % 3) != 1;
    #1;
    run     = if_pwr && (conv_on || keep_alive);
    e_bclk  = run && ((m_phase >= m_ratio / 2) ^ m_inv);
    in_slot = run && (m_bit >= m_off) && (m_bit < m_off + m_w);
    e_sd    = in_slot ? cur_samp[m_w - 1 - (m_bit - m_off)] : 1'b0;
    e_rdy   = run && (m_phase == m_ratio - 1) && (m_bit == m_flen - 1);
    chk(bclk_o,   e_bclk, m_inv ? "R4" : "R1", "bclk_o");
    chk(wclk_o,   run && (m_bit == 0), "R2", "wclk_o");
    chk(sdout_o,  e_sd, "R3", "sdout_o");
    chk(sdout_oe, if_pwr && (in_slot || !m_hiz), "R5", "sdout_oe");
    chk(bclk_oe,  if_pwr, "R8", "bclk_oe");
    chk(wclk_oe,  if_pwr, "R8", "wclk_oe");
    chk(s_ready,  e_rdy, "R6", "s_ready");
    if (!run) chk(bclk_o | wclk_o, 1'b0, "R9", "idle clocks");
    prev_ready = e_rdy; prev_valid = s_valid; prev_data = s_data;
  endtask

  task automatic run_frames(input int frames);
    int f0 = frame_idx;
    while (frame_idx < f0 + frames && !done) step();
  endtask

  task automatic go_idle();
    conv_on = 0; keep_alive = 0;
    step(); step();
  endtask

  task automatic set_cfg(input int dv, input int ln, input int off, input int ws,
                         input bit inv, input bit hiz);
    cfg_div = 7'(dv); cfg_len = 8'(ln); cfg_offset = 8'(off);
    cfg_wsel = 2'(ws); cfg_inv = inv; cfg_hiz = hiz;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state, interface unpowered
    repeat (3) @(negedge clk);
    #1;
    chk(bclk_oe | wclk_oe | sdout_oe, 1'b0, "R8", "reset oe");
    chk(bclk_o | wclk_o | sdout_o | s_ready, 1'b0, "R8", "reset outputs");
    @(negedge clk);
    rst_n = 1;
    step();
    if_pwr = 1;
    step(); step();

    // R1 R3 R4 R5 R6: sweep divide, word length, offset, polarity, release mode
    for (int d = 1; d <= 4; d++)
      for (int ws = 0; ws < 4; ws++)
        for (int oi = 0; oi < 2; oi++)
          for (int iv = 0; iv < 2; iv++)
            for (int hz = 0; hz < 2; hz++) begin
              go_idle();
              set_cfg(d, 39, oi * 9, ws, iv[0], hz[0]);
              step();
              conv_on = 1;
              run_frames(3);
            end

    // R1 R2: largest ratio with a short frame code (clamps to 16 bit clocks)
    go_idle();
    set_cfg(0, 5, 2, 1, 0, 1);
    step();
    conv_on = 1;
    run_frames(2);

    // R7: mid-frame change takes effect only at the next frame
    go_idle();
    set_cfg(3, 39, 0, 0, 0, 1);
    step();
    conv_on = 1;
    repeat (50) step();
    set_cfg(4, 47, 7, 2, 1, 0);
    run_frames(3);

    // R9: keep-alive runs clocks with the converter off
    go_idle();
    set_cfg(2, 19, 1, 0, 0, 1);
    step();
    keep_alive = 1;
    run_frames(2);
    keep_alive = 0;
    repeat (5) step();

    // R9: converter off mid-frame restarts the frame when it returns
    conv_on = 1;
    repeat (27) step();
    conv_on = 0;
    repeat (4) step();
    conv_on = 1;
    run_frames(2);

    // R8: interface power removed mid-run
    repeat (13) step();
    if_pwr = 0;
    repeat (6) step();
    if_pwr = 1;
    run_frames(2);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule